// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a system-monitor watchdog for a small controller. A fixed divider splits the oscillator clock by twelve and feeds a prescaler. The prescaler divides by a power of two chosen in software, and its output advances a 14-bit timer. When the timer wraps while the watchdog is enabled, the block drives a one-clock internal reset pulse and sets a time-out flag.

Software controls the block through one 8-bit register at address 0x8F. Software keeps the watchdog quiet by writing its clear bit. That request is held until the next instruction-cycle strobe. On that strobe the whole counting chain restarts from zero and the clear bit drops back to 0.

An idle-mode input freezes the chain unless the idle-run bit is set. The timer width is a parameter, so a test can shorten the time-out period.

Top module: `wdog_prescaled`

## Requirements
- R1: While the external reset is high, and after it falls, the control register reads 0x00, `wdt_reset_o` and `timeout_o` are low, and the divider, prescaler and timer hold zero. This also drops a clear request that was still pending.
- R2: A write with `wr_addr_i` equal to 0x8F loads the control register. Bit 7 is enable, bit 6 is clear, bit 5 is idle-run and bits 2:0 are the prescale select. Bits 4:3 always read 0. A write to any other address leaves the register unchanged.
- R3: The time-out period is OSC_DIV × 2^(select+1) × 2^TIMER_W oscillator clocks. Count from the clock edge that takes in the enabling write. `wdt_reset_o` is high in the cycle that follows the period-th later edge.
- R4: `wdt_reset_o` is high for exactly one clock. The timer then wraps to zero and keeps counting, so a second pulse follows one full period after the first.
- R5: `timeout_o` rises together with `wdt_reset_o`. It stays high until a clear action or a reset.
- R6: A written clear bit reads back as 1 until the next clock edge with `instr_stb_i` high. That edge zeroes the divider, prescaler and timer, and afterwards the clear bit reads 0.
- R7: While the enable bit is 0, the chain holds its value and no pulse occurs. Enabling again resumes counting from the held value.
- R8: With `idle_i` high and idle-run 0, the chain holds for every clock edge spent in idle, which delays the time-out by exactly that many clocks. With idle-run 1, idle has no effect on the timing.
- R9: A clear action on the same edge as a timer overflow wins. No pulse occurs, the flag is not set, and the next time-out is one full period after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | External reset, active high, synchronous |
| idle_i | input | 1 | High while the processor is in idle mode |
| instr_stb_i | input | 1 | One-clock strobe, once per instruction cycle |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| ctrl_rdata_o | output | 8 | Current control register value |
| wdt_reset_o | output | 1 | One-clock internal reset pulse on time-out |
| timeout_o | output | 1 | Sticky time-out flag |

## Verification
Two events can land on the same edge: the clear action taken from a pending clear request, and the timer overflow. The bench enables the watchdog and posts a clear request well before the time-out. It then waits until the cycle just before the computed overflow edge and raises the instruction strobe, so that the clear action lands exactly on that edge. The result is judged at the ports. No pulse may appear, the flag must stay low, and the next pulse must arrive exactly one full period after the strobe edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int SEL_W    = 3;
    localparam int REG_W    = 8;
    localparam int EN_BIT   = 7;
    localparam int CLR_BIT  = 6;
    localparam int IDLE_BIT = 5;

    typedef struct packed {
        logic             en;
        logic             kick;
        logic             idle_run;
        logic [SEL_W-1:0] sel;
    } wdog_ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_to_byte(wdog_ctrl_t c);
        logic [REG_W-1:0] b;
        b           = '0;
        b[EN_BIT]   = c.en;
        b[CLR_BIT]  = c.kick;
        b[IDLE_BIT] = c.idle_run;
        b[SEL_W-1:0] = c.sel;
        return b;
    endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              clr_act_i,
    output wdog_ctrl_t        ctrl_o
);

    typedef struct packed {
        wdog_ctrl_t ctrl;
    } state_t;

    state_t s_d, s_q;
    logic   hit;
    logic   unused_bits;

    assign hit         = wr_en_i && (wr_addr_i == CTRL_ADDR);
    assign unused_bits = ^wr_data_i[IDLE_BIT-1:SEL_W];

    always_comb begin
        s_d = s_q;
        if (clr_act_i) begin
            s_d.ctrl.kick = 1'b0;
        end
        if (hit) begin
            s_d.ctrl.en       = wr_data_i[EN_BIT];
            s_d.ctrl.kick     = wr_data_i[CLR_BIT];
            s_d.ctrl.idle_run = wr_data_i[IDLE_BIT];
            s_d.ctrl.sel      = wr_data_i[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o = s_q.ctrl;

endmodule

// File: rtl/wdog_osc_div.sv
module wdog_osc_div #(
    parameter int DIV = 12
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);

    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;
    logic   at_last;

    assign at_last = (s_q.cnt == LAST);

    always_comb begin
        s_d    = s_q;
        tick_o = 1'b0;
        if (restart_i) begin
            s_d.cnt = '0;
        end else if (run_i) begin
            if (at_last) begin
                s_d.cnt = '0;
                tick_o  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    localparam int PRE_W = 1 << SEL_W;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } state_t;

    state_t           s_d, s_q;
    logic [PRE_W-1:0] mask;
    logic             at_limit;

    // bit i of the mask is set when i <= select, so the divisor is 2^(select+1)
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i <= int'(sel_i));
        end
    end

    assign at_limit = ((s_q.cnt & mask) == mask);

    always_comb begin
        s_d    = s_q;
        tick_o = 1'b0;
        if (restart_i) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            if (at_limit) begin
                s_d.cnt = '0;
                tick_o  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int TIMER_W = 14
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic restart_i,
    output logic ovf_o
);

    typedef struct packed {
        logic [TIMER_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        ovf_o = 1'b0;
        if (restart_i) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
            ovf_o   = &s_q.cnt;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
    import wdog_pkg::*;
#(
    parameter int                OSC_DIV   = 12,
    parameter int                TIMER_W   = 14,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              idle_i,
    input  logic              instr_stb_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  ctrl_rdata_o,
    output logic              wdt_reset_o,
    output logic              timeout_o
);

    typedef struct packed {
        logic pulse;
        logic flag;
    } state_t;

    state_t     s_d, s_q;
    wdog_ctrl_t ctrl;
    logic       run;
    logic       clr_act;
    logic       div_tick;
    logic       pre_tick;
    logic       ovf;

    wdog_ctrl_reg #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) i_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .clr_act_i (clr_act),
        .ctrl_o    (ctrl)
    );

    // a pending clear acts on the next instruction strobe; counting needs enable and no blocking idle
    assign clr_act = instr_stb_i && ctrl.kick;
    assign run     = ctrl.en && (!idle_i || ctrl.idle_run);

    wdog_osc_div #(
        .DIV       (OSC_DIV)
    ) i_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (run),
        .restart_i (clr_act),
        .tick_o    (div_tick)
    );

    wdog_prescaler #(
        .SEL_W     (SEL_W)
    ) i_pre (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (div_tick),
        .restart_i (clr_act),
        .sel_i     (ctrl.sel),
        .tick_o    (pre_tick)
    );

    wdog_timer #(
        .TIMER_W   (TIMER_W)
    ) i_tmr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (pre_tick),
        .restart_i (clr_act),
        .ovf_o     (ovf)
    );

    always_comb begin
        s_d       = s_q;
        s_d.pulse = ovf;
        if (clr_act) begin
            s_d.flag = 1'b0;
        end else if (ovf) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_rdata_o = ctrl_to_byte(ctrl);
    assign wdt_reset_o  = s_q.pulse;
    assign timeout_o    = s_q.flag;

endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              idle_i,
    input logic              instr_stb_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [7:0]        ctrl_rdata_o,
    input logic              wdt_reset_o,
    input logic              timeout_o
);

    a_r2_unused_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_rdata_o[4:3] == 2'b00);

    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_reset_o |=> !wdt_reset_o);

    a_r5_flag_with_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_reset_o |-> timeout_o);

    a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (rst_i)
        (instr_stb_i && ctrl_rdata_o[6] && !(wr_en_i && wr_addr_i == CTRL_ADDR)) |=> !ctrl_rdata_o[6]);

    a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctrl_rdata_o[7] |=> !wdt_reset_o);

    a_r8_idle_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        (idle_i && !ctrl_rdata_o[5]) |=> !wdt_reset_o);

    a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        (instr_stb_i && ctrl_rdata_o[6]) |=> !wdt_reset_o);

endmodule

bind wdog_prescaled wdog_prescaled_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) i_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .idle_i       (idle_i),
    .instr_stb_i  (instr_stb_i),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .ctrl_rdata_o (ctrl_rdata_o),
    .wdt_reset_o  (wdt_reset_o),
    .timeout_o    (timeout_o)
);

// File: tb/test_wdog_prescaled.sv
module test_wdog_prescaled;

    localparam int DIV = 12;
    localparam int TW  = 4;

    logic       clk     = 1'b0;
    logic       rst     = 1'b1;
    logic       idle    = 1'b0;
    logic       stb     = 1'b0;
    logic       wr_en   = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rdata;
    logic       pulse;
    logic       tmo;

    int cyc      = 0;
    int checks   = 0;
    int errors   = 0;
    int last     = 0;
    int exp_q[$];
    int exp_cyc;
    bit prev     = 1'b0;
    bit finished = 1'b0;

    wdog_prescaled #(
        .OSC_DIV   (DIV),
        .TIMER_W   (TW)
    ) i_wdog_prescaled (
        .clk_i        (clk),
        .rst_i        (rst),
        .idle_i       (idle),
        .instr_stb_i  (stb),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .ctrl_rdata_o (rdata),
        .wdt_reset_o  (pulse),
        .timeout_o    (tmo)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int period(int sel);
        return DIV * (2 ** (sel + 1)) * (2 ** TW);
    endfunction

    task automatic chk_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all driver tasks start and end just after a falling edge
    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        last  = cyc;
    endtask

    task automatic strobe();
        stb = 1'b1;
        @(posedge clk); @(negedge clk);
        stb  = 1'b0;
        last = cyc;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    task automatic expect_pulse(int c);
        exp_q.push_back(c);
    endtask

    task automatic drain_check(string req);
        chk_eq(req, exp_q.size(), 0);
    endtask

    // monitor: pops the expected pulse cycle for every pulse seen
    always @(negedge clk) begin
        if (rst) begin
            prev <= 1'b0;
        end else begin
            if (prev) chk_eq("R4 single-cycle pulse", int'(pulse), 0);
            if (pulse) begin
                if (exp_q.size() == 0) begin
                    chk_eq("R7 unexpected pulse cycle", cyc, -1);
                end else begin
                    exp_cyc = exp_q.pop_front();
                    chk_eq("R3 pulse cycle", cyc, exp_cyc);
                    chk_eq("R5 flag with pulse", int'(tmo), 1);
                end
            end
            prev <= pulse;
        end
    end

    initial begin
        int c0;
        int done;
        wait_cyc(5);
        chk_eq("R1 reg during reset", int'(rdata), 0);
        rst = 1'b0;
        wait_cyc(1);
        chk_eq("R1 reg after reset", int'(rdata), 0);
        chk_eq("R1 pulse after reset", int'(pulse), 0);
        chk_eq("R1 flag after reset", int'(tmo), 0);

        // R2: address decode and unused bits
        wr(8'h8E, 8'h80);
        chk_eq("R2 other address ignored", int'(rdata), 0);
        wr(8'h8F, 8'h1B);
        chk_eq("R2 unused bits read zero", int'(rdata), 8'h03);
        wr(8'h8F, 8'h00);

        // R3, R4, R7, R5: periodic pulses, hold, resume, flag clear
        wr(8'h8F, 8'h80);
        c0 = last;
        expect_pulse(c0 + period(0));
        expect_pulse(c0 + 2 * period(0));
        wait_until(c0 + 2 * period(0) + 12);
        drain_check("R4 second pulse seen");
        wr(8'h8F, 8'h00);
        done = (last - c0) % period(0);
        wait_cyc(1000);
        chk_eq("R5 flag sticky", int'(tmo), 1);
        wr(8'h8F, 8'h80);
        expect_pulse(last + period(0) - done);
        wait_until(last + period(0) - done + 3);
        drain_check("R7 resumed from held value");
        wr(8'h8F, 8'h00);
        wr(8'h8F, 8'h40);
        chk_eq("R6 clear pending", int'(rdata), 8'h40);
        strobe();
        chk_eq("R5 flag cleared by clear action", int'(tmo), 0);
        chk_eq("R6 clear bit self-clears", int'(rdata), 0);

        // R6: pending clear restarts the chain on the strobe edge
        do_reset();
        wr(8'h8F, 8'h80);
        wait_cyc(100);
        wr(8'h8F, 8'hC0);
        wait_cyc(20);
        chk_eq("R6 clear waits for strobe", int'(rdata), 8'hC0);
        strobe();
        chk_eq("R6 clear done", int'(rdata), 8'h80);
        expect_pulse(last + period(0));
        wait_until(last + period(0) + 3);
        drain_check("R6 restart timing");

        // R3: prescale select 1 and 3
        do_reset();
        wr(8'h8F, 8'h81);
        expect_pulse(last + period(1));
        wait_until(last + period(1) + 3);
        drain_check("R3 select 1");
        do_reset();
        wr(8'h8F, 8'h83);
        expect_pulse(last + period(3));
        wait_until(last + period(3) + 3);
        drain_check("R3 select 3");

        // R8: idle freezes with idle-run 0
        do_reset();
        wr(8'h8F, 8'h80);
        c0 = last;
        expect_pulse(c0 + period(0) + 50);
        wait_cyc(100);
        idle = 1'b1;
        wait_cyc(50);
        idle = 1'b0;
        wait_until(c0 + period(0) + 53);
        drain_check("R8 idle freeze delay");

        // R8: idle-run 1 keeps counting
        do_reset();
        wr(8'h8F, 8'hA0);
        c0 = last;
        expect_pulse(c0 + period(0));
        wait_cyc(100);
        idle = 1'b1;
        wait_cyc(50);
        idle = 1'b0;
        wait_until(c0 + period(0) + 3);
        drain_check("R8 idle-run no delay");

        // R9: clear action on the overflow edge
        do_reset();
        wr(8'h8F, 8'h80);
        c0 = last;
        wait_cyc(30);
        wr(8'h8F, 8'hC0);
        wait_until(c0 + period(0) - 1);
        strobe();
        chk_eq("R9 strobe landed on overflow edge", last, c0 + period(0));
        wait_cyc(2);
        chk_eq("R9 no pulse on collision", int'(pulse), 0);
        chk_eq("R9 flag stays low", int'(tmo), 0);
        expect_pulse(last + period(0));
        wait_until(last + period(0) + 3);
        drain_check("R9 next period");

        // R1: reset drops a pending clear
        wr(8'h8F, 8'hC7);
        do_reset();
        wait_cyc(1);
        chk_eq("R1 reset clears register", int'(rdata), 0);
        chk_eq("R1 reset clears flag", int'(tmo), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog expired: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule